// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is one 8-bit control register together with its interrupt request logic. The register holds two global gates, an enable for each of three interrupt sources, and a sticky flag for each source. The three sources are a timer overflow pulse, an external edge pulse, and a change detector that watches four port pins. Software reads and writes the register over a small strobe bus. Hardware events set the flags at any time, so software can poll them even while interrupts are disabled. A flag clears only when software writes a 0 to it.

The block drives two request outputs, high and low. When `prio_mode_i` is low, the two global bits act as a master gate and a peripheral-group gate, and all requests appear on `irq_hi_o`. When `prio_mode_i` is high, the same two bits become a high-priority gate and a low-priority gate. A per-source select input then sends each request to one of the two outputs. A peripheral-group request from outside the block joins the same gating.

Top module: `irq_ctrl_reg`

## Requirements
- R1: The register bits, from bit 7 down to bit 0, are: gate A (global or high-priority), gate B (peripheral or low-priority), timer enable, external enable, change enable, timer flag, external flag, change flag. A write stores the whole byte. While `rd_en_i` is high, `rd_data_o` returns the register in the same cycle. While `rd_en_i` is low, `rd_data_o` is 0.
- R2: After reset, bits 7 to 1 are 0 and both request outputs are low. The reset value of bit 0 is not guaranteed.
- R3: A high `tmr_ovf_i` sets bit 2 at the next clock, and a high `ext_evt_i` sets bit 1 at the next clock. This happens whatever the state of any enable bit.
- R4: A set flag stays set until software writes a 0 to it. Idle cycles leave it set.
- R5: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R6: The four pins go through a two-stage synchronizer. Bit 0 becomes set at the clock after the synchronized pins differ from a stored reference, which is three clocks after a pin change. The reference reloads from the synchronized pins on each cycle with `port_rd_i` high. Once the reference matches the pins, clearing the flag makes it stay clear.
- R7: When `prio_mode_i` is 0, `irq_hi_o` equals bit 7 AND (any source whose flag and enable are both 1, OR (bit 6 AND `periph_req_i`)). In this mode `irq_lo_o` is 0.
- R8: When `prio_mode_i` is 1, a source is high priority when its `prio_sel_i` bit is 1; bit index 2 is the timer, 1 is external, and 0 is change. `periph_prio_i` does the same for the peripheral request. Active high-priority requests drive `irq_hi_o` gated by bit 7. Active low-priority requests drive `irq_lo_o` gated by both bit 7 and bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prio_mode_i | input | 1 | Selects the two-level priority scheme |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Register read data, combinational |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| ext_evt_i | input | 1 | External edge event pulse |
| port_pins_i | input | 4 | Monitored port pins, asynchronous |
| port_rd_i | input | 1 | Port read strobe; reloads the change reference |
| prio_sel_i | input | 3 | Priority select per source (1 = high) |
| periph_req_i | input | 1 | Peripheral-group request |
| periph_prio_i | input | 1 | Priority select for the peripheral request |
| irq_hi_o | output | 1 | High-priority (or only) interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |

## Verification
The bench drives a timer event and a software clear of the timer flag in the same cycle. A design that let the write win would read back a clear flag and lose the event. It then holds a pin mismatch while software clears the change flag. It checks that the flag re-sets, and that it stays clear only after a port read reloads the reference. The bench also reads the register one cycle before the flag should rise: a synchronizer that was one stage short would show the flag too early. In priority mode, each source is steered to both outputs while gate B is toggled. A design that applied gate B to high-priority requests, or that ignored the select bits, would raise the wrong output.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_SRC   = 3;
  localparam int unsigned FLAG_LSB  = 0;
  localparam int unsigned EN_LSB    = FLAG_LSB + NUM_SRC;
  localparam int unsigned GATE_B    = EN_LSB + NUM_SRC;
  localparam int unsigned GATE_A    = GATE_B + 1;
  // source index = flag bit = enable bit - EN_LSB
  localparam int unsigned SRC_CHG   = 0;
  localparam int unsigned SRC_EXT   = 1;
  localparam int unsigned SRC_TMR   = 2;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_change_det.sv
module irq_change_det #(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                load_i,
  output logic                chg_o
);
  logic [NUM_PINS-1:0] pins_s;
  logic [NUM_PINS-1:0] ref_q;

  irq_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     ref_q <= '0;
    else if (load_i) ref_q <= pins_s;

  assign chg_o = (pins_s != ref_q);
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [REG_W-1:0]   ctrl_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = wr_data_i;
    // hardware set applied after the write: events are never lost
    ctrl_d[NUM_SRC-1:0] = ctrl_d[NUM_SRC-1:0] | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_reg_pkg::*;
(
  input  logic               prio_mode_i,
  input  logic [REG_W-1:0]   ctrl_i,
  input  logic [NUM_SRC-1:0] prio_sel_i,
  input  logic               periph_req_i,
  input  logic               periph_prio_i,
  output logic               irq_hi_o,
  output logic               irq_lo_o
);
  logic [NUM_SRC-1:0] active;
  logic               gate_a, gate_b;

  assign active = ctrl_i[FLAG_LSB +: NUM_SRC] & ctrl_i[EN_LSB +: NUM_SRC];
  assign gate_a = ctrl_i[GATE_A];
  assign gate_b = ctrl_i[GATE_B];

  always_comb begin
    if (!prio_mode_i) begin
      irq_hi_o = gate_a & ((|active) | (gate_b & periph_req_i));
      irq_lo_o = 1'b0;
    end else begin
      irq_hi_o = gate_a & ((|(active & prio_sel_i)) | (periph_req_i & periph_prio_i));
      irq_lo_o = gate_a & gate_b &
                 ((|(active & ~prio_sel_i)) | (periph_req_i & ~periph_prio_i));
    end
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_reg_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prio_mode_i,
  input  logic                wr_en_i,
  input  logic [REG_W-1:0]    wr_data_i,
  input  logic                rd_en_i,
  output logic [REG_W-1:0]    rd_data_o,
  input  logic                tmr_ovf_i,
  input  logic                ext_evt_i,
  input  logic [NUM_PINS-1:0] port_pins_i,
  input  logic                port_rd_i,
  input  logic [NUM_SRC-1:0]  prio_sel_i,
  input  logic                periph_req_i,
  input  logic                periph_prio_i,
  output logic                irq_hi_o,
  output logic                irq_lo_o
);
  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0] src_evt;
  logic               chg_evt;

  irq_change_det #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) i_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(port_pins_i),
    .load_i(port_rd_i),
    .chg_o (chg_evt)
  );

  always_comb begin
    src_evt          = '0;
    src_evt[SRC_TMR] = tmr_ovf_i;
    src_evt[SRC_EXT] = ext_evt_i;
    src_evt[SRC_CHG] = chg_evt;
  end

  irq_ctrl_bank #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .set_i    (src_evt),
    .ctrl_o   (ctrl_q)
  );

  irq_req_gen i_req (
    .prio_mode_i  (prio_mode_i),
    .ctrl_i       (ctrl_q),
    .prio_sel_i   (prio_sel_i),
    .periph_req_i (periph_req_i),
    .periph_prio_i(periph_prio_i),
    .irq_hi_o     (irq_hi_o),
    .irq_lo_o     (irq_lo_o)
  );

  assign rd_data_o = rd_en_i ? ctrl_q : '0;
endmodule

// File: rtl/irq_ctrl_reg_chk.sv
module irq_ctrl_reg_chk
  import irq_reg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prio_mode_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             tmr_ovf_i,
  input logic             ext_evt_i,
  input logic [REG_W-1:0] ctrl_i,
  input logic             irq_hi_o,
  input logic             irq_lo_o
);
  assert_ctrl_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ctrl_i[REG_W-1:EN_LSB] == $past(wr_data_i[REG_W-1:EN_LSB]));

  assert_tmr_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> ctrl_i[SRC_TMR]);

  assert_ext_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_evt_i |=> ctrl_i[SRC_EXT]);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sticky
    assert_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_i[s] && !wr_en_i) |=> ctrl_i[s]);
  end

  assert_no_lo_flat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prio_mode_i |-> !irq_lo_o);

  assert_gate_a_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[GATE_A] |-> (!irq_hi_o && !irq_lo_o));

  assert_gate_b_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[GATE_B] |-> !irq_lo_o);
endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prio_mode_i(prio_mode_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .tmr_ovf_i  (tmr_ovf_i),
  .ext_evt_i  (ext_evt_i),
  .ctrl_i     (ctrl_q),
  .irq_hi_o   (irq_hi_o),
  .irq_lo_o   (irq_lo_o)
);

// File: tb/test_irq_ctrl_reg.sv
module test_irq_ctrl_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       prio_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       tmr_ovf_i = 1'b0;
  logic       ext_evt_i = 1'b0;
  logic [3:0] port_pins_i = '0;
  logic       port_rd_i = 1'b0;
  logic [2:0] prio_sel_i = '0;
  logic       periph_req_i = 1'b0;
  logic       periph_prio_i = 1'b0;
  logic       irq_hi_o, irq_lo_o;

  irq_ctrl_reg i_irq_ctrl_reg (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int         kind;  // 0 rd_data, 1 irq_hi, 2 irq_lo
    logic [7:0] exp;
    logic [7:0] mask;
    string      req;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // monitor: compares at the falling edge, away from input changes
  always @(negedge clk_i) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rd_data_o;
        1:       act = {7'b0, irq_hi_o};
        default: act = {7'b0, irq_lo_o};
      endcase
      total++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind,
                 act & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic push(int kind, logic [7:0] exp, logic [7:0] mask, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.mask = mask; it.req = req;
    q.push_back(it);
  endtask

  task automatic rd_exp(logic [7:0] exp, logic [7:0] mask, string req);
    rd_en_i = 1'b1;
    push(0, exp, mask, req);
    step();
    rd_en_i = 1'b0;
  endtask

  task automatic irq_exp(logic hi, logic lo, string req);
    push(1, {7'b0, hi}, 8'h01, req);
    push(2, {7'b0, lo}, 8'h01, req);
    step();
  endtask

  task automatic wr(logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_ni = 1'b1;
    step();
    // R2: reset state, bit 0 excluded
    rd_exp(8'h00, 8'hFE, "R2");
    irq_exp(1'b0, 1'b0, "R2");
    wr(8'h00);
    // R1: full byte store, same-cycle read, idle read returns 0
    wr(8'hA5);
    rd_exp(8'hA5, 8'hFF, "R1");
    push(0, 8'h00, 8'hFF, "R1 idle");
    step();
    wr(8'h00);
    rd_exp(8'h00, 8'hFF, "R1");
    // R3: timer and external flags with all enables off
    tmr_ovf_i = 1'b1; step(); tmr_ovf_i = 1'b0;
    rd_exp(8'h04, 8'hFF, "R3 tmr");
    // R4: sticky through idle cycles, cleared by a 0 write
    repeat (3) step();
    rd_exp(8'h04, 8'hFF, "R4 sticky");
    wr(8'h00);
    rd_exp(8'h00, 8'hFF, "R4 clear");
    ext_evt_i = 1'b1; step(); ext_evt_i = 1'b0;
    rd_exp(8'h02, 8'hFF, "R3 ext");
    wr(8'h00);
    // R5: set and clear in the same cycle
    tmr_ovf_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h00;
    step();
    tmr_ovf_i = 1'b0; wr_en_i = 1'b0;
    rd_exp(8'h04, 8'hFF, "R5 set wins");
    wr(8'h00);
    // R6: change detection through the synchronizer
    port_pins_i = 4'b0100;
    step(); step();
    rd_exp(8'h00, 8'hFF, "R6 sync latency");
    rd_exp(8'h01, 8'hFF, "R6 change");
    wr(8'h00);
    rd_exp(8'h01, 8'hFF, "R5 mismatch persists");
    port_rd_i = 1'b1; step(); port_rd_i = 1'b0;
    wr(8'h00);
    rd_exp(8'h00, 8'hFF, "R6 reload");
    step(); step();
    rd_exp(8'h00, 8'hFF, "R6 stays clear");
    port_pins_i = 4'b1001;
    repeat (3) step();
    rd_exp(8'h01, 8'hFF, "R6 second pattern");
    port_rd_i = 1'b1; step(); port_rd_i = 1'b0;
    wr(8'h00);
    rd_exp(8'h00, 8'hFF, "R6 reload 2");
    // R7: flat mode
    wr(8'hA4);
    irq_exp(1'b1, 1'b0, "R7 tmr");
    wr(8'h24);
    irq_exp(1'b0, 1'b0, "R7 gate A off");
    wr(8'h84);
    irq_exp(1'b0, 1'b0, "R7 enable off");
    wr(8'h89);
    irq_exp(1'b1, 1'b0, "R7 chg");
    wr(8'h92);
    irq_exp(1'b1, 1'b0, "R7 ext");
    periph_req_i = 1'b1;
    wr(8'h80);
    irq_exp(1'b0, 1'b0, "R7 periph gate B off");
    wr(8'hC0);
    irq_exp(1'b1, 1'b0, "R7 periph");
    periph_req_i = 1'b0;
    irq_exp(1'b0, 1'b0, "R7 periph drop");
    // R8: priority mode
    prio_mode_i = 1'b1;
    prio_sel_i = 3'b000;
    wr(8'hA4);
    irq_exp(1'b0, 1'b0, "R8 low needs gate B");
    wr(8'hE4);
    irq_exp(1'b0, 1'b1, "R8 tmr low");
    prio_sel_i = 3'b100;
    irq_exp(1'b1, 1'b0, "R8 tmr high");
    wr(8'hA4);
    irq_exp(1'b1, 1'b0, "R8 high ignores gate B");
    wr(8'h64);
    irq_exp(1'b0, 1'b0, "R8 gate A off");
    wr(8'hF6);
    irq_exp(1'b1, 1'b1, "R8 mixed");
    wr(8'hC0);
    periph_req_i = 1'b1; periph_prio_i = 1'b0;
    irq_exp(1'b0, 1'b1, "R8 periph low");
    periph_prio_i = 1'b1;
    irq_exp(1'b1, 1'b0, "R8 periph high");
    wr(8'h40);
    irq_exp(1'b0, 1'b0, "R8 periph gate A off");
    periph_req_i = 1'b0;
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule